// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. The first level is a bank of branch-history shift registers. The second level is a pattern table of 2-bit saturating counters, indexed by a history pattern combined with branch address bits. A fetch stage presents a branch PC on the predict port and gets a taken/not-taken answer in the same cycle. When the branch resolves, the execute stage presents the same PC and the real outcome on the update port. On that clock edge the counter that was used is trained, and the outcome is shifted into the history register.

Four parameters select the organisation:
- `HIST_REGS` sets the number of history registers.
- `HIST_W` sets the width of each history register.
- `CTR_ENTRIES` sets the number of counters.
- `XOR_IDX` chooses between concatenating and XOR-folding the address into the index.

With these four values the block forms a global or per-address history, and a shared or per-address pattern table. For example, one register with 2^W counters gives a single global table. N registers with N·2^W counters give per-address histories and per-address tables.

Top module: `bp_two_level`

## Requirements
- R1: After reset every counter holds 1 (weakly not-taken) and every history register is all zeros, so the prediction is not-taken for any PC.
- R2: The prediction is bit 1 of the counter selected by the predict PC. Counter values 2 and 3 predict taken; 0 and 1 predict not-taken.
- R3: A taken update increments the selected counter, and a counter at 3 stays at 3.
- R4: A not-taken update decrements the selected counter, and a counter at 0 stays at 0.
- R5: The history register used for a PC is number (PC >> 2) mod HIST_REGS. An update shifts that register left by one and places the outcome (1 = taken) in bit 0. The oldest bit is dropped and the other registers are left unchanged.
- R6: With XOR_IDX = 0, the counter index is the low log2(CTR_ENTRIES) bits of {PC >> 2, history}, with the history in the low bits. An update trains the counter indexed by the history as it was before the shift.
- R7: With XOR_IDX = 1, the counter index is the low log2(CTR_ENTRIES) bits of (PC >> 2) XOR history.
- R8: The prediction depends only on the current state, with no register in the path. An update presented in a cycle affects predictions only from the next clock edge onward.
- R9: While upd_valid_i is low, no counter and no history register changes, whatever the other update inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | PC_W | PC of the branch to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | Resolved branch present |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The prediction is combinational, so the bench reads it one nanosecond after setting pred_pc_i, always within the low clock phase. An update takes effect on the first rising edge after it is presented. The bench updates its reference model at that same edge and compares only afterwards. In one scenario it also reads the prediction for the updated PC before the edge, and expects the old state. Two instances run the same stimulus side by side: one uses per-address history with concatenated indexing, and the other uses a single global history with XOR indexing. Every comparison therefore covers both index forms.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'd1;

  function automatic ctr_t ctr_next(ctr_t c, logic taken);
    ctr_t n;
    if (taken) n = (c == 2'd3) ? 2'd3 : c + 2'd1;
    else       n = (c == 2'd0) ? 2'd0 : c - 2'd1;
    return n;
  endfunction
endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table #(
  parameter int unsigned N      = 4,
  parameter int unsigned W      = 4,
  parameter int unsigned SEL_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [W-1:0]     rd_hist_o,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             wr_taken_i,
  output logic [W-1:0]     wr_hist_o
);
  logic [N-1:0][W-1:0] hist_q;

  for (genvar r = 0; r < N; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        hist_q[r] <= '0;
      else if (wr_en_i && (int'(wr_sel_i) == r))
        hist_q[r] <= {hist_q[r][W-2:0], wr_taken_i};
    end
  end

  assign rd_hist_o = hist_q[rd_sel_i];
  assign wr_hist_o = hist_q[wr_sel_i];

  p_shift_in_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> hist_q[$past(wr_sel_i)][0] == $past(wr_taken_i));

  p_shift_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> hist_q[$past(wr_sel_i)][W-1:1] == $past(wr_hist_o[W-2:0]));

  p_hist_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(hist_q));
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int unsigned PCW_W   = 30,
  parameter int unsigned W       = 4,
  parameter int unsigned IDX_W   = 6,
  parameter bit          XOR_IDX = 1'b0
) (
  input  logic [PCW_W-1:0] pcw_i,
  input  logic [W-1:0]     hist_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int unsigned WIDE = PCW_W + W;

  logic [WIDE-1:0] mix;

  if (XOR_IDX) begin : g_xor
    assign mix = WIDE'(pcw_i) ^ WIDE'(hist_i);
  end else begin : g_cat
    assign mix = {pcw_i, hist_i};
  end

  assign idx_o = mix[IDX_W-1:0];
endmodule

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
#(
  parameter int unsigned M     = 64,
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  ctr_t [M-1:0] ctr_q;

  for (genvar e = 0; e < M; e++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ctr_q[e] <= CTR_RESET;
      else if (wr_en_i && (int'(wr_idx_i) == e))
        ctr_q[e] <= ctr_next(ctr_q[e], wr_taken_i);
    end
  end

  assign rd_ctr_o = ctr_q[rd_idx_i];

  p_sat_top_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_taken_i && ctr_q[wr_idx_i] == 2'd3) |=> ctr_q[$past(wr_idx_i)] == 2'd3);

  p_sat_bot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_taken_i && ctr_q[wr_idx_i] == 2'd0) |=> ctr_q[$past(wr_idx_i)] == 2'd0);

  p_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_taken_i && ctr_q[wr_idx_i] != 2'd3)
      |=> ctr_q[$past(wr_idx_i)] == $past(ctr_q[wr_idx_i]) + 2'd1);

  p_ctr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctr_q));
endmodule

// File: rtl/bp_two_level.sv
module bp_two_level
  import bp_pkg::*;
#(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned ALIGN_BITS  = 2,
  parameter int unsigned HIST_REGS   = 4,
  parameter int unsigned HIST_W      = 4,
  parameter int unsigned CTR_ENTRIES = 64,
  parameter bit          XOR_IDX     = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned PCW_W  = PC_W - ALIGN_BITS;
  localparam int unsigned HSEL_W = (HIST_REGS > 1) ? $clog2(HIST_REGS) : 1;
  localparam int unsigned IDX_W  = (CTR_ENTRIES > 1) ? $clog2(CTR_ENTRIES) : 1;

  function automatic logic [HSEL_W-1:0] hist_sel(logic [PCW_W-1:0] w);
    return HSEL_W'(w % PCW_W'(HIST_REGS));
  endfunction

  logic [PCW_W-1:0]  pred_pcw, upd_pcw;
  logic [HSEL_W-1:0] pred_sel, upd_sel;
  logic [HIST_W-1:0] pred_hist, upd_hist;
  logic [IDX_W-1:0]  pred_idx, upd_idx;
  ctr_t              pred_ctr;

  assign pred_pcw = pred_pc_i[PC_W-1:ALIGN_BITS];
  assign upd_pcw  = upd_pc_i[PC_W-1:ALIGN_BITS];
  assign pred_sel = hist_sel(pred_pcw);
  assign upd_sel  = hist_sel(upd_pcw);

  bp_hist_table #(.N(HIST_REGS), .W(HIST_W), .SEL_W(HSEL_W)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_sel_i   (pred_sel),
    .rd_hist_o  (pred_hist),
    .wr_en_i    (upd_valid_i),
    .wr_sel_i   (upd_sel),
    .wr_taken_i (upd_taken_i),
    .wr_hist_o  (upd_hist)
  );

  bp_index #(.PCW_W(PCW_W), .W(HIST_W), .IDX_W(IDX_W), .XOR_IDX(XOR_IDX)) u_pred_idx (
    .pcw_i  (pred_pcw),
    .hist_i (pred_hist),
    .idx_o  (pred_idx)
  );

  // training uses the pre-shift history
  bp_index #(.PCW_W(PCW_W), .W(HIST_W), .IDX_W(IDX_W), .XOR_IDX(XOR_IDX)) u_upd_idx (
    .pcw_i  (upd_pcw),
    .hist_i (upd_hist),
    .idx_o  (upd_idx)
  );

  bp_pht #(.M(CTR_ENTRIES), .IDX_W(IDX_W)) u_pht (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (pred_idx),
    .rd_ctr_o   (pred_ctr),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_idx),
    .wr_taken_i (upd_taken_i)
  );

  assign pred_taken_o = pred_ctr[1];

  initial begin
    a_cfg_hist_w: assert (HIST_W >= 2);
    a_cfg_pow2: assert (CTR_ENTRIES == (1 << IDX_W));
  end
endmodule

// File: tb/tb_bp_two_level.sv
module tb_bp_two_level;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        upd_v = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_t = 1'b0;
  logic        pred_a, pred_b;
  int          checks = 0;
  int          errors = 0;

  always #10 clk = ~clk;

  // per-address history, concatenated index
  bp_two_level #(.HIST_REGS(4), .HIST_W(4), .CTR_ENTRIES(64), .XOR_IDX(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pred_pc_i(pred_pc), .pred_taken_o(pred_a),
    .upd_valid_i(upd_v), .upd_pc_i(upd_pc), .upd_taken_i(upd_t));

  // single global history, xor index
  bp_two_level #(.HIST_REGS(1), .HIST_W(4), .CTR_ENTRIES(16), .XOR_IDX(1'b1)) dut_x (
    .clk_i(clk), .rst_ni(rst_n), .pred_pc_i(pred_pc), .pred_taken_o(pred_b),
    .upd_valid_i(upd_v), .upd_pc_i(upd_pc), .upd_taken_i(upd_t));

  logic [3:0] ha [4];
  logic [1:0] ca [64];
  logic [3:0] hb;
  logic [1:0] cb [16];

  function automatic logic [1:0] sat(logic [1:0] c, logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  function automatic int idx_a(logic [31:0] pc);
    return int'({pc[3:2], ha[pc[3:2]]});
  endfunction

  function automatic int idx_b(logic [31:0] pc);
    return int'(hb ^ pc[5:2]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) ha[i] = '0;
    for (int i = 0; i < 64; i++) ca[i] = 2'd1;
    hb = '0;
    for (int i = 0; i < 16; i++) cb[i] = 2'd1;
  endtask

  task automatic model_update(logic [31:0] pc, logic t);
    int ia, ib;
    ia = idx_a(pc);
    ib = idx_b(pc);
    ca[ia] = sat(ca[ia], t);
    cb[ib] = sat(cb[ib], t);
    ha[pc[3:2]] = {ha[pc[3:2]][2:0], t};
    hb = {hb[2:0], t};
  endtask

  task automatic chk(logic [31:0] pc, string tag);
    logic ea, eb;
    pred_pc = pc;
    #1;
    ea = ca[idx_a(pc)][1];
    eb = cb[idx_b(pc)][1];
    checks++;
    if (pred_a !== ea) begin
      errors++;
      $display("FAIL %s concat pc=%h actual=%b expected=%b", tag, pc, pred_a, ea);
    end
    checks++;
    if (pred_b !== eb) begin
      errors++;
      $display("FAIL %s/R7 xor pc=%h actual=%b expected=%b", tag, pc, pred_b, eb);
    end
  endtask

  task automatic do_update(logic [31:0] pc, logic t);
    @(negedge clk);
    upd_v = 1'b1; upd_pc = pc; upd_t = t;
    @(posedge clk);
    model_update(pc, t);
    #1 upd_v = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    for (int i = 0; i < 8; i++) chk(32'h1000 + 32'(i * 4), "R1");
  endtask

  task automatic t_sat_up();
    for (int i = 0; i < 9; i++) do_update(32'h40, 1'b1);
    @(negedge clk);
    chk(32'h40, "R3");
    chk(32'h44, "R3");
  endtask

  task automatic t_sat_down();
    for (int i = 0; i < 7; i++) do_update(32'h44, 1'b0);
    @(negedge clk);
    chk(32'h44, "R4");
    do_update(32'h44, 1'b1);
    @(negedge clk);
    chk(32'h44, "R4");
    chk(32'h40, "R4");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    upd_v = 1'b1; upd_pc = 32'h48; upd_t = 1'b1;
    chk(32'h48, "R8");
    @(posedge clk);
    model_update(32'h48, 1'b1);
    #1 upd_v = 1'b0;
    @(negedge clk);
    chk(32'h48, "R8");
  endtask

  task automatic t_hist_pattern();
    logic [7:0] pat = 8'b1011_0010;
    for (int i = 0; i < 24; i++) begin
      do_update(32'h20 + 32'((i % 3) * 4), pat[i % 8]);
      @(negedge clk);
      chk(32'h20, "R5");
      chk(32'h24, "R6");
      chk(32'h2C, "R6");
    end
  endtask

  task automatic t_alternate();
    for (int i = 0; i < 20; i++) begin
      do_update(32'h80, 1'(i % 2));
      @(negedge clk);
      chk(32'h80, "R2");
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    upd_v = 1'b0;
    for (int i = 0; i < 4; i++) begin
      upd_pc = 32'h40 + 32'(i * 4);
      upd_t = 1'(i % 2);
      @(negedge clk);
    end
    chk(32'h40, "R9");
    chk(32'h44, "R9");
    chk(32'h80, "R9");
    chk(32'h20, "R9");
  endtask

  initial begin
    model_reset();
    #35 rst_n = 1'b1;
    t_reset();
    t_sat_up();
    t_sat_down();
    t_same_cycle();
    t_hist_pattern();
    t_alternate();
    t_idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule